// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block keeps the mode register of a DDR-style SDRAM and turns each read or write command into the series of column addresses that the burst visits, one per clock. A mode-set command writes the register only when the bank-select field is zero and the controller reports every bank idle. The stored burst length and burst order then set the counter that walks the columns. The counter stays inside an aligned block of columns whose size equals the burst length, and it wraps at the block edge.

The block places the CAS latency field and the operating-mode field of the register on ports so that neighbouring logic can use them. An error pulse reports a mode load that came while a bank was open, and a read or write that was issued while the stored burst length was a reserved code. The block does not handle DRAM timing, refresh or data capture.

Top module: `burst_col_seq`

## Requirements
- R1: A mode-set command (`cmd_op` = 2'b11) with a non-zero `cmd_ba` leaves the register unchanged and raises no error.
- R2: Register layout: bits 2:0 hold the burst-length code (3'b001 = 2, 3'b010 = 4, 3'b011 = 8), bit 3 holds the order (0 sequential, 1 interleaved), bits 6:4 appear on `cas_lat`, and bits 11:7 appear on `opmode`.
- R3: Register bit 8 (`opmode[1]`) reads 1 for exactly one cycle after a load that set it, and then reads 0.
- R4: A mode-set with `cmd_ba` = 0 while `banks_idle` = 0 pulses `cfg_err` for one cycle and leaves the register unchanged.
- R5: A read or write issued while the stored burst-length code is reserved (3'b000 or 3'b100 to 3'b111) starts no burst and pulses `cfg_err` for one cycle.
- R6: In sequential order, the low bits of beat n are (start + n) mod L, where L is the burst length and start is the command column's low log2(L) bits. The column bits above those low bits stay equal to the command column for the whole burst.
- R7: In interleaved order, the low bits of beat n are start XOR n, and the upper bits are held as in R6.
- R8: Reads (`cmd_op` = 2'b01) and writes (`cmd_op` = 2'b10) produce the same address sequence.
- R9: Beat 0 appears with `col_vld` high in the cycle after the command. One beat follows per cycle, `col_last` is high on beat L-1 only, and `col_vld` is low in the cycle after the last beat.
- R10: A read or write accepted on the last-beat cycle, or at any point in a burst, puts beat 0 of the new burst out in the next cycle with no idle cycle in between.
- R11: After reset the register holds burst length 2, sequential order, `cas_lat` = 3'b010 and `opmode` = 0, with `col_vld` and `cfg_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_vld | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 none, 01 read, 10 write, 11 mode set |
| cmd_ba | input | BA_W (2) | Bank-select field |
| cmd_addr | input | ADDR_W (12) | Address bus: register data or column address |
| banks_idle | input | 1 | High when every bank is idle |
| col_addr | output | COL_W (10) | Column address of the current beat |
| col_vld | output | 1 | Beat present |
| col_last | output | 1 | Final beat of the burst |
| cas_lat | output | 3 | Stored CAS latency field |
| opmode | output | 5 | Stored operating-mode field |
| cfg_err | output | 1 | One-cycle pulse on an illegal load or an illegal burst start |

## Verification
The bench sweeps every legal length, both orders, both command types and all eight start offsets over two block bases. One base has all the upper column bits set, so a counter whose carry escaped the block would corrupt those bits, and a design that used the wrong mask for a length would leave the block or repeat beats. Separate cases load the register with a bank open or with a non-zero bank field, and a faulty gate would show there as a changed CAS latency or a changed burst length on the next burst. Other cases cover a reserved length code, which must give an error and no beats, the single-cycle life of the self-clearing bit, and back-to-back or interrupting commands, where a design that inserts a gap cycle or finishes the old burst would be caught.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_RD   = 2'b01,
    OP_WR   = 2'b10,
    OP_MRS  = 2'b11
  } bcs_op_e;

  localparam int unsigned MR_W       = 12;
  localparam int unsigned SELFCLR_IX = 8;
  localparam int unsigned LOW_W      = 3;
  localparam logic [MR_W-1:0] MR_RST = 12'h021;

  // low-bit mask for a burst-length code; zero for reserved codes
  function automatic logic [LOW_W-1:0] bl_mask(input logic [2:0] code);
    logic [LOW_W-1:0] m;
    case (code)
      3'b001:  m = 3'b001;
      3'b010:  m = 3'b011;
      3'b011:  m = 3'b111;
      default: m = 3'b000;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
  import bcs_pkg::*;
#(
  parameter int unsigned BA_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mrs_req,
  input  logic [BA_W-1:0] ba,
  input  logic [MR_W-1:0] wdata,
  input  logic            banks_idle,
  output logic [MR_W-1:0] mode_q,
  output logic            load_err
);

  localparam logic [MR_W-1:0] SC_MASK = MR_W'(1) << SELFCLR_IX;

  logic            hit;
  logic            load;
  logic            mode_en;
  logic [MR_W-1:0] mode_d;

  always_comb begin
    hit      = mrs_req && (ba == '0);
    load     = hit && banks_idle;
    load_err = hit && !banks_idle;
    mode_en  = load || mode_q[SELFCLR_IX];
    mode_d   = mode_q & ~SC_MASK;
    if (load) mode_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MR_RST;
    else if (mode_en) mode_q <= mode_d;
  end

  // R1
  ba_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mrs_req && ba != '0) |=> ((mode_q & ~SC_MASK) == ($past(mode_q) & ~SC_MASK)));

  // R4
  busy_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mrs_req && !banks_idle) |=> ((mode_q & ~SC_MASK) == ($past(mode_q) & ~SC_MASK)));

  // R3
  self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[SELFCLR_IX] && !mrs_req) |=> !mode_q[SELFCLR_IX]);

endmodule

// File: rtl/bcs_burst_ctr.sv
module bcs_burst_ctr
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic [COL_W-1:0] col_in,
  input  logic [2:0]       bl_code,
  input  logic             ilv,
  output logic [COL_W-1:0] col_addr,
  output logic             col_vld,
  output logic             col_last,
  output logic             start_err
);

  localparam int unsigned HI_W = COL_W - LOW_W;

  logic             act_q,   act_d;
  logic [LOW_W-1:0] n_q,     n_d;
  logic [LOW_W-1:0] start_q, start_d;
  logic [LOW_W-1:0] mask_q,  mask_d;
  logic             ilv_q,   ilv_d;
  logic [COL_W-1:0] base_q,  base_d;
  logic             ctr_en;
  logic [LOW_W-1:0] new_mask;
  logic             start_ok;
  logic [LOW_W-1:0] low;

  always_comb begin
    new_mask  = bl_mask(bl_code);
    start_ok  = start_req && (new_mask != '0);
    start_err = start_req && (new_mask == '0);
    col_vld   = act_q;
    col_last  = act_q && (n_q == mask_q);
    act_d     = act_q;
    n_d       = n_q;
    start_d   = start_q;
    mask_d    = mask_q;
    ilv_d     = ilv_q;
    base_d    = base_q;
    if (start_ok) begin
      act_d   = 1'b1;
      n_d     = '0;
      start_d = col_in[LOW_W-1:0] & new_mask;
      mask_d  = new_mask;
      ilv_d   = ilv;
      base_d  = col_in;
    end else if (col_last) begin
      act_d = 1'b0;
    end else begin
      n_d = n_q + 1'b1;
    end
    ctr_en = start_ok || act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      n_q     <= '0;
      start_q <= '0;
      mask_q  <= '0;
      ilv_q   <= 1'b0;
      base_q  <= '0;
    end else if (ctr_en) begin
      act_q   <= act_d;
      n_q     <= n_d;
      start_q <= start_d;
      mask_q  <= mask_d;
      ilv_q   <= ilv_d;
      base_q  <= base_d;
    end
  end

  always_comb begin
    if (ilv_q) low = (start_q ^ n_q) & mask_q;
    else       low = (start_q + n_q) & mask_q;
    col_addr = (base_q & ~{{HI_W{1'b0}}, mask_q}) | {{HI_W{1'b0}}, low};
  end

  // R9
  last_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_vld);

  // R9
  burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_last && !start_req) |=> !col_vld);

  // R6
  block_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_vld && !col_last && !start_req) |=>
      (col_vld && col_addr[COL_W-1:LOW_W] == $past(col_addr[COL_W-1:LOW_W])));

  // R5
  no_bad_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_err && !col_vld) |=> !col_vld);

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int unsigned BA_W   = 2,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned COL_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_vld,
  input  logic [1:0]        cmd_op,
  input  logic [BA_W-1:0]   cmd_ba,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              banks_idle,
  output logic [COL_W-1:0]  col_addr,
  output logic              col_vld,
  output logic              col_last,
  output logic [2:0]        cas_lat,
  output logic [4:0]        opmode,
  output logic              cfg_err
);

  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic            mrs_req;
  logic            burst_req;
  logic [MR_W-1:0] mode_q;
  logic            load_err;
  logic            start_err;
  logic            err_d;
  logic            err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    mrs_req   = cmd_vld && (bcs_op_e'(cmd_op) == OP_MRS);
    burst_req = cmd_vld && ((bcs_op_e'(cmd_op) == OP_RD) || (bcs_op_e'(cmd_op) == OP_WR));
    err_d     = load_err || start_err;
  end

  bcs_mode_reg #(.BA_W(BA_W)) u_mode (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .mrs_req    (mrs_req),
    .ba         (cmd_ba),
    .wdata      (cmd_addr[MR_W-1:0]),
    .banks_idle (banks_idle),
    .mode_q     (mode_q),
    .load_err   (load_err)
  );

  bcs_burst_ctr #(.COL_W(COL_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_req (burst_req),
    .col_in    (cmd_addr[COL_W-1:0]),
    .bl_code   (mode_q[2:0]),
    .ilv       (mode_q[3]),
    .col_addr  (col_addr),
    .col_vld   (col_vld),
    .col_last  (col_last),
    .start_err (start_err)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) err_q <= 1'b0;
    else            err_q <= err_d;
  end

  assign cfg_err = err_q;
  assign cas_lat = mode_q[6:4];
  assign opmode  = mode_q[11:7];

  // R4
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mrs_req && cmd_ba == '0 && !banks_idle) |=> cfg_err);

endmodule

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_vld;
  logic [1:0]  cmd_op;
  logic [1:0]  cmd_ba;
  logic [11:0] cmd_addr;
  logic        banks_idle;
  logic [9:0]  col_addr;
  logic        col_vld;
  logic        col_last;
  logic [2:0]  cas_lat;
  logic [4:0]  opmode;
  logic        cfg_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  burst_col_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
    .cmd_ba(cmd_ba), .cmd_addr(cmd_addr), .banks_idle(banks_idle),
    .col_addr(col_addr), .col_vld(col_vld), .col_last(col_last),
    .cas_lat(cas_lat), .opmode(opmode), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive a command for one edge; returns at the negedge after it
  task automatic issue(input logic [1:0] op, input logic [1:0] ba,
                       input logic [11:0] a, input logic idle);
    @(negedge clk);
    cmd_vld = 1'b1; cmd_op = op; cmd_ba = ba; cmd_addr = a; banks_idle = idle;
    @(negedge clk);
    cmd_vld = 1'b0; cmd_op = 2'b00; banks_idle = 1'b1;
  endtask

  function automatic int exp_addr(input int col, input int code, input int il, input int n);
    int m, s, lo;
    m  = (2 << (code - 1)) - 1;
    s  = col & m;
    lo = il ? ((s ^ n) & m) : ((s + n) & m);
    return (col & ~m & 10'h3FF) | lo;
  endfunction

  // checks all beats of a burst already launched; ends at the last-beat negedge
  task automatic follow(input string req, input int col, input int code, input int il);
    int len;
    len = 2 << (code - 1);
    for (int n = 0; n < len; n++) begin
      if (n > 0) @(negedge clk);
      chk({req, " addr"}, col_addr, exp_addr(col, code, il, n));
      chk("R9 vld", col_vld, 1);
      chk("R9 last", col_last, (n == len - 1) ? 1 : 0);
    end
  endtask

  task automatic burst(input string req, input logic [1:0] op, input int col,
                       input int code, input int il);
    issue(op, 2'b00, 12'(col), 1'b1);
    follow(req, col, code, il);
    @(negedge clk);
    chk("R9 idle after last", col_vld, 0);
  endtask

  task automatic mrs(input int code, input int il, input int cl);
    issue(2'b11, 2'b00, 12'((cl << 4) | (il << 3) | code), 1'b1);
    chk("R2 load no error", cfg_err, 0);
    chk("R2 cas_lat", cas_lat, cl);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_vld = 1'b0; cmd_op = 2'b00; cmd_ba = 2'b00;
    cmd_addr = '0; banks_idle = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk("R11 col_vld", col_vld, 0);
    chk("R11 cfg_err", cfg_err, 0);
    chk("R11 cas_lat", cas_lat, 3'b010);
    chk("R11 opmode", opmode, 0);
    burst("R11 default BL2 seq", 2'b01, 10'h1A3, 1, 0);

    // R6 R7 R8 full sweep
    for (int code = 1; code <= 3; code++)
      for (int il = 0; il < 2; il++) begin
        mrs(code, il, 3);
        for (int s = 0; s < 8; s++)
          for (int b = 0; b < 2; b++) begin
            int col;
            col = (b == 0) ? (10'h3F8 | s) : (10'h0A0 | s);
            burst(il ? "R7 interleaved" : "R6 sequential",
                  b[0] ? 2'b10 : 2'b01, col, code, il);
          end
      end

    // R8 explicit read vs write at same column, BL8 interleaved
    mrs(3, 1, 2);
    burst("R8 read", 2'b01, 10'h2D5, 3, 1);
    burst("R8 write", 2'b10, 10'h2D5, 3, 1);

    // R10 back-to-back on last beat, BL4 sequential
    mrs(2, 0, 2);
    issue(2'b01, 2'b00, 12'h105, 1'b1);
    follow("R10 first", 10'h105, 2, 0);
    cmd_vld = 1'b1; cmd_op = 2'b10; cmd_addr = 12'h3FE;
    @(negedge clk);
    cmd_vld = 1'b0; cmd_op = 2'b00;
    follow("R10 back-to-back", 10'h3FE, 2, 0);
    @(negedge clk);
    chk("R10 idle after", col_vld, 0);

    // R10 interrupt mid-burst, BL8 sequential
    mrs(3, 0, 2);
    issue(2'b01, 2'b00, 12'h040, 1'b1);
    @(negedge clk);
    cmd_vld = 1'b1; cmd_op = 2'b01; cmd_addr = 12'h0F3;
    @(negedge clk);
    cmd_vld = 1'b0; cmd_op = 2'b00;
    burst_tail: begin
      follow("R10 interrupt", 10'h0F3, 3, 0);
    end

    // R4 load with a bank open: error, register unchanged
    mrs(2, 1, 3);
    issue(2'b11, 2'b00, 12'h051, 1'b0);
    chk("R4 cfg_err", cfg_err, 1);
    @(negedge clk);
    chk("R4 err one cycle", cfg_err, 0);
    chk("R4 cas_lat kept", cas_lat, 3);
    burst("R4 length kept", 2'b01, 10'h006, 2, 1);

    // R1 non-zero bank field ignored
    issue(2'b11, 2'b01, 12'h011, 1'b1);
    chk("R1 no error", cfg_err, 0);
    chk("R1 cas_lat kept", cas_lat, 3);
    issue(2'b11, 2'b10, 12'h011, 1'b1);
    chk("R1 cas_lat kept ba2", cas_lat, 3);
    burst("R1 length kept", 2'b10, 10'h1C1, 2, 1);

    // R2 R3 self-clearing bit and opmode field
    issue(2'b11, 2'b00, 12'hD21, 1'b1);
    chk("R3 bit set", opmode, 5'b11010);
    chk("R2 cas_lat field", cas_lat, 3'b010);
    @(negedge clk);
    chk("R3 bit cleared", opmode, 5'b11000);
    @(negedge clk);
    chk("R3 stays cleared", opmode, 5'b11000);
    burst("R2 BL2 seq field", 2'b01, 10'h311, 1, 0);

    // R5 reserved burst-length codes
    issue(2'b11, 2'b00, 12'h020, 1'b1);
    issue(2'b01, 2'b00, 12'h077, 1'b1);
    chk("R5 err code 000", cfg_err, 1);
    chk("R5 no burst 000", col_vld, 0);
    @(negedge clk);
    chk("R5 still idle", col_vld, 0);
    chk("R5 err one cycle", cfg_err, 0);
    issue(2'b11, 2'b00, 12'h027, 1'b1);
    issue(2'b10, 2'b00, 12'h077, 1'b1);
    chk("R5 err code 111", cfg_err, 1);
    chk("R5 no burst 111", col_vld, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule